// File: doc/BRIEF.md
# Secondary Bus Master Acquisition Unit

This unit sits inside a secondary bus master, such as a DMA engine, and handles the takeover of a shared bus. The engine pulses `need_bus_i` when it wants the bus. The unit then raises a bus request and waits for a grant. It also waits until the bus is free: the address strobe is idle, the grant acknowledge line is idle, and, when configured, the data acknowledge is idle. Only then does it claim the bus. It claims the bus by driving the shared open-drain grant acknowledge line. At the same moment it drops the request and tells its own cycle engine that it owns the bus.

The engine signals completion with `xfer_done_i`. The unit then stops driving grant acknowledge, spends one clock in a release state and returns to idle. If the grant goes away before the bus becomes free, the unit keeps requesting and waits for a new grant.

All bus-side inputs are active-high views of the sampled bus lines (1 = asserted). They pass through a `SYNC_STAGES`-deep synchronizer before the control logic uses them. `need_bus_i`, `xfer_done_i` and `use_dack_i` are already synchronous to `clk_i`.

Top module: `alt_master_acq`

## Requirements
- R1: While reset is active and on the first cycle after it, `bus_req_o`, `gack_drive_o` and `owner_o` are 0.
- R2: A `need_bus_i` pulse while idle sets `bus_req_o` to 1 on the next clock edge. `bus_req_o` stays 1 until ownership is taken.
- R3: Ownership is taken only while the synchronized grant is 1 and the bus is free. With a free bus, `owner_o` rises SYNC_STAGES+2 clocks after the grant is applied. With the grant already seen, `owner_o` rises SYNC_STAGES+1 clocks after the last blocking input is removed.
- R4: Ownership is never taken while the synchronized address strobe is 1.
- R5: Ownership is never taken while another master's grant acknowledge (`gack_i`) is 1.
- R6: With `use_dack_i`=1, a data acknowledge of 1 blocks takeover. With `use_dack_i`=0, data acknowledge has no effect on takeover.
- R7: While owner, `gack_drive_o`=1, `owner_o`=1 and `bus_req_o`=0.
- R8: Once owner, the unit stays owner until `xfer_done_i`, whatever the bus inputs do.
- R9: `xfer_done_i` while owner gives exactly one clock with `gack_drive_o`=0, `owner_o`=0 and `bus_req_o`=0. The unit then returns to idle and accepts a new `need_bus_i`.
- R10: If the grant drops before takeover, `bus_req_o` stays 1 and no takeover happens, even if the bus then becomes free. Takeover proceeds only after the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| need_bus_i | input | 1 | Engine wants the bus (pulse) |
| xfer_done_i | input | 1 | Engine finished its bus cycles |
| use_dack_i | input | 1 | 1: data acknowledge is part of the bus-free test |
| grant_i | input | 1 | Bus grant (asserted-high view) |
| strobe_i | input | 1 | Address strobe (asserted-high view) |
| dack_i | input | 1 | Data acknowledge (asserted-high view) |
| gack_i | input | 1 | Grant acknowledge line (asserted-high view) |
| bus_req_o | output | 1 | Bus request |
| gack_drive_o | output | 1 | Pull-down enable for the open-drain grant acknowledge |
| owner_o | output | 1 | Unit is bus master |

## Verification
The bench builds the unit with the default SYNC_STAGES=2, which keeps every latency short enough to check on an exact cycle. For both values of `use_dack_i`, it sweeps all eight combinations of strobe, data acknowledge and grant acknowledge. For each combination it checks that the takeover decision is correct, and that takeover comes on the exact clock once the blockers clear. Further sequences cover grant loss in the waiting state, bus activity during ownership, and the one-clock release.

// File: rtl/alt_master_acq_pkg.sv
package alt_master_acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQUEST,
    ST_WAIT_FREE,
    ST_OWNER,
    ST_RELEASE
  } acq_state_e;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/acq_free_check.sv
module acq_free_check (
  input  logic strobe_i,
  input  logic dack_i,
  input  logic gack_i,
  input  logic use_dack_i,
  output logic free_o
);
  logic dack_busy;
  assign dack_busy = use_dack_i & dack_i;
  assign free_o    = ~strobe_i & ~gack_i & ~dack_busy;
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import alt_master_acq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic need_bus_i,
  input  logic xfer_done_i,
  input  logic grant_s_i,
  input  logic strobe_s_i,
  input  logic bus_free_i,
  output logic bus_req_o,
  output logic gack_drive_o,
  output logic owner_o
);
  acq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (need_bus_i) state_d = ST_REQUEST;
      ST_REQUEST:   if (grant_s_i) state_d = ST_WAIT_FREE;
      ST_WAIT_FREE: if (!grant_s_i) state_d = ST_REQUEST;
                    else if (bus_free_i) state_d = ST_OWNER;
      ST_OWNER:     if (xfer_done_i) state_d = ST_RELEASE;
      ST_RELEASE:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign bus_req_o    = (state_q == ST_REQUEST) || (state_q == ST_WAIT_FREE);
  assign owner_o      = (state_q == ST_OWNER);
  assign gack_drive_o = (state_q == ST_OWNER);

  // ownership never starts while the strobe is seen busy
  assert_no_take_on_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_o && strobe_s_i) |=> !owner_o);
  assert_owner_drops_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_o |-> (gack_drive_o && !bus_req_o));
  assert_hold_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o && !xfer_done_i) |=> owner_o);
  assert_release_one_clk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o && xfer_done_i) |=> (!gack_drive_o && !bus_req_o));
  assert_no_take_without_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_o && !grant_s_i) |=> !owner_o);
  assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_free_i) |=> bus_req_o);
endmodule

// File: rtl/alt_master_acq.sv
module alt_master_acq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic need_bus_i,
  input  logic xfer_done_i,
  input  logic use_dack_i,
  input  logic grant_i,
  input  logic strobe_i,
  input  logic dack_i,
  input  logic gack_i,
  output logic bus_req_o,
  output logic gack_drive_o,
  output logic owner_o
);
  localparam int NUM_IN = 4;

  logic [NUM_IN-1:0] raw_in, sync_in;
  logic grant_s, strobe_s, dack_s, gack_s, bus_free;

  assign raw_in = {grant_i, strobe_i, dack_i, gack_i};

  acq_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_in)
  );

  assign {grant_s, strobe_s, dack_s, gack_s} = sync_in;

  acq_free_check u_free (
    .strobe_i   (strobe_s),
    .dack_i     (dack_s),
    .gack_i     (gack_s),
    .use_dack_i (use_dack_i),
    .free_o     (bus_free)
  );

  acq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .need_bus_i   (need_bus_i),
    .xfer_done_i  (xfer_done_i),
    .grant_s_i    (grant_s),
    .strobe_s_i   (strobe_s),
    .bus_free_i   (bus_free),
    .bus_req_o    (bus_req_o),
    .gack_drive_o (gack_drive_o),
    .owner_o      (owner_o)
  );

  // another master's acknowledge blocks takeover
  assert_no_take_on_gack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_o && gack_s) |=> !owner_o);
  assert_dack_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_o && use_dack_i && dack_s) |=> !owner_o);
endmodule

// File: tb/alt_master_acq_tb.sv
module alt_master_acq_tb;
  localparam int SYNC = 2;

  logic clk = 0, rst_ni = 0;
  logic need_bus = 0, done = 0, use_dack = 0;
  logic grant = 0, strobe = 0, dack = 0, gack = 0;
  logic bus_req, gack_drive, owner;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  alt_master_acq #(.SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .need_bus_i(need_bus), .xfer_done_i(done),
    .use_dack_i(use_dack), .grant_i(grant), .strobe_i(strobe), .dack_i(dack),
    .gack_i(gack), .bus_req_o(bus_req), .gack_drive_o(gack_drive), .owner_o(owner)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request();
    need_bus = 1; cyc(1); need_bus = 0;
  endtask

  task automatic finish_own();
    done = 1; cyc(1); done = 0;
    chk("R9 owner", owner, 0);
    chk("R9 gack", gack_drive, 0);
    chk("R9 req", bus_req, 0);
    cyc(1);
    chk("R9 idle", bus_req, 0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 req", bus_req, 0);
    chk("R1 gack", gack_drive, 0);
    chk("R1 owner", owner, 0);
    rst_ni = 1;
    cyc(1);
    chk("R1 owner post", owner, 0);

    // sweep config x blocker pattern
    for (int u = 0; u < 2; u++) begin
      for (int p = 0; p < 8; p++) begin
        logic exp_free;
        use_dack = u[0];
        strobe = p[0]; dack = p[1]; gack = p[2];
        exp_free = !p[0] && !p[2] && !(u[0] && p[1]);
        request();
        chk("R2 req", bus_req, 1);
        grant = 1;
        cyc(SYNC + 1);
        chk("R3 latency early", owner, 0);
        cyc(1);
        chk(p[0] ? "R4 block" : p[2] ? "R5 block" : "R6 dack", owner, exp_free);
        if (!exp_free) begin
          chk("R2 req hold", bus_req, 1);
          cyc(3);
          chk("R4/R5/R6 still blocked", owner, 0);
          strobe = 0; dack = 0; gack = 0;
          cyc(SYNC);
          chk("R3 free latency early", owner, 0);
          cyc(1);
          chk("R3 free latency", owner, 1);
        end
        chk("R7 gack", gack_drive, 1);
        chk("R7 req", bus_req, 0);
        grant = 0;
        finish_own();
      end
    end

    // grant lost before bus free
    use_dack = 1;
    strobe = 1;
    request();
    grant = 1;
    cyc(SYNC + 3);
    grant = 0;
    cyc(SYNC + 2);
    chk("R10 req", bus_req, 1);
    strobe = 0;
    cyc(6);
    chk("R10 no take", owner, 0);
    chk("R10 req held", bus_req, 1);
    grant = 1;
    cyc(SYNC + 1);
    chk("R10 early", owner, 0);
    cyc(1);
    chk("R10 take", owner, 1);

    // bus activity during ownership
    grant = 0; strobe = 1; dack = 1; gack = 1;
    cyc(6);
    chk("R8 hold", owner, 1);
    chk("R8 gack", gack_drive, 1);
    strobe = 0; dack = 0; gack = 0;
    cyc(3);
    chk("R8 hold2", owner, 1);
    finish_own();

    // new request after release
    request();
    chk("R9 rerequest", bus_req, 1);
    grant = 1;
    cyc(SYNC + 2);
    chk("R9 reown", owner, 1);
    grant = 0;
    finish_own();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule